// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block carries out one complete NAND flash operation for every command word written to it. The low six bits of the word pick an encoded sequence. The sequence fixes the order in which command bytes, address bytes, a ready wait and a data phase go out on the flash pins. The block drives the command-latch and address-latch enables, the write and read strobes and an 8-bit I/O bus. It takes write data from a byte stream with valid/ready handshake. It returns read data on a byte stream that has a valid strobe and no backpressure.

Two address sets are provided, each built from a pair of 32-bit words. Each set has its own 3-bit address-cycle count in the control word. After the last command byte the block waits for the flash to drop its ready line and raise it again. On completion it posts a command-end event into a small interrupt status register, which a mask reduces to a single interrupt line. The ready line is synchronised, and the block also presents it as an all-ones or all-zeros device status byte.

Top module: `nand_cmd_seq`

## Requirements
- R1: Command word fields: sequence code in [5:0], address-set select in bit 7 (0 takes {addr_a_hi, addr_a_lo}, 1 takes {addr_b_hi, addr_b_lo}), first command byte in [15:8], second command byte in [23:16].
- R2: Every flash byte transfer holds its strobe low for exactly one clock, then high for at least one. nand_we_n is used for command, address and write bytes, and nand_re_n for read bytes. nand_cle is high only with command bytes and nand_ale only with address bytes. Read data is captured from nand_io_in at the end of the low clock.
- R3: Code 0x00 sends the first command byte, then performs the ready wait.
- R4: Code 0x0E sends the first command byte, the address bytes, the second command byte, then the ready wait, with no data phase.
- R5: Code 0x0C sends the first command byte and the address bytes. It then sends data_size bytes taken from the write stream, with one byte accepted per cycle in which wr_valid and wr_ready are both high. The second command byte and the ready wait follow. A data_size of zero skips the data phase.
- R6: Code 0x21 sends the first command byte and exactly one address byte, whatever the count field holds. It then reads data_size bytes, each presented on rd_data with a one-cycle rd_valid.
- R7: Code 0x2A sends the first command byte and exactly five address bytes. The second command byte and the ready wait follow, and then data_size bytes are read.
- R8: Code 0x24 sends the first command byte and reads one byte into read_status, without raising rd_valid.
- R9: Code 0x32 sends the first command byte and the address bytes, performs the ready wait, then reads data_size bytes. Zero bytes gives no read phase.
- R10: Where the address count is not fixed, it is ctrl_word[2:0] for set 0 and ctrl_word[20:18] for set 1. Address bytes leave least-significant first from the selected 64-bit value. A count of zero sends no address bytes.
- R11: The ready wait first lets WB_GAP clocks pass. It then holds, with no strobe, until the synchronised nand_rb is high. dev_status reads 0xFF while the synchronised ready is high and 0x00 while it is low.
- R12: busy rises the cycle after an accepted command write and falls once the sequence has finished. A command write while busy is ignored. Codes other than the seven listed are ignored: no busy and no strobes.
- R13: int_status bit 1 sets when a sequence ends. Bit 4 sets when the synchronised ready line rises. An int_clr pulse clears the register. irq is high whenever a status bit is also set in int_mask.
- R14: After reset, strobes are high, nand_cle and nand_ale are low, busy is low, int_status is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Sequence code, address-set select, command bytes |
| ctrl_word | input | 32 | Address-cycle counts for the two address sets |
| addr_a_lo | input | 32 | Address set 0, low word |
| addr_a_hi | input | 32 | Address set 0, high word |
| addr_b_lo | input | 32 | Address set 1, low word |
| addr_b_hi | input | 32 | Address set 1, high word |
| data_size | input | LEN_W | Data phase length in bytes |
| busy | output | 1 | Sequence in progress |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte accepted this cycle |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid (one cycle) |
| read_status | output | 8 | Byte captured by the status sequence |
| dev_status | output | 8 | 0xFF when the device is ready, else 0x00 |
| int_mask | input | 8 | Interrupt enable per status bit |
| int_clr | input | 1 | Clears the interrupt status |
| int_status | output | 8 | Interrupt status bits |
| irq | output | 1 | Interrupt line |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Flash I/O bus, outgoing byte |
| nand_io_oe | output | 1 | Flash I/O bus output enable |
| nand_io_in | input | 8 | Flash I/O bus, incoming byte |
| nand_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The bench sends every sequence code through a table with distinct command bytes, both address sets and varied count fields and lengths. It compares the complete logged pin transaction list in order, which catches any swap of command, address and data phases or any wrong byte order. Some table entries place a count in the unselected control field, or in a field that a fixed-count code must disregard, so that a wrong field choice shows up. Other entries use zero counts and zero lengths, which separate "skip the phase" from "do one transfer". Directed tests then hold the ready line low to show that the wait gates the data phase, write a second command while busy, issue an undefined code, and walk the interrupt mask.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    typedef enum logic [2:0] {
        ST_CMD0  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CMD1  = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4,
        ST_WAIT  = 3'd5,
        ST_STAT  = 3'd6,
        ST_END   = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        BK_CMD  = 2'd0,
        BK_ADDR = 2'd1,
        BK_WR   = 2'd2,
        BK_RD   = 2'd3
    } bkind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ph_e;

    localparam int PLAN_LEN = 6;
    typedef logic [PLAN_LEN-1:0][2:0] plan_t;

    localparam logic [5:0] SEQ_CMD_ONLY = 6'h00;
    localparam logic [5:0] SEQ_ERASE    = 6'h0E;
    localparam logic [5:0] SEQ_PROG     = 6'h0C;
    localparam logic [5:0] SEQ_ID       = 6'h21;
    localparam logic [5:0] SEQ_LP_READ  = 6'h2A;
    localparam logic [5:0] SEQ_STATUS   = 6'h24;
    localparam logic [5:0] SEQ_SP_READ  = 6'h32;

endpackage

// File: rtl/nfs_decode.sv
module nfs_decode
    import nfs_pkg::*;
(
    input  logic [5:0] code,
    input  logic [2:0] cyc_field,
    output logic       known,
    output plan_t      plan,
    output logic [2:0] naddr
);

    function automatic plan_t mk(step_e s0, step_e s1, step_e s2,
                                 step_e s3, step_e s4, step_e s5);
        return {s5, s4, s3, s2, s1, s0};
    endfunction

    always_comb begin
        known = 1'b1;
        naddr = cyc_field;
        plan  = mk(ST_END, ST_END, ST_END, ST_END, ST_END, ST_END);
        case (code)
            SEQ_CMD_ONLY: plan = mk(ST_CMD0, ST_WAIT, ST_END, ST_END, ST_END, ST_END);
            SEQ_ERASE:    plan = mk(ST_CMD0, ST_ADDR, ST_CMD1, ST_WAIT, ST_END, ST_END);
            SEQ_PROG:     plan = mk(ST_CMD0, ST_ADDR, ST_WDATA, ST_CMD1, ST_WAIT, ST_END);
            SEQ_ID: begin
                plan  = mk(ST_CMD0, ST_ADDR, ST_RDATA, ST_END, ST_END, ST_END);
                naddr = 3'd1;
            end
            SEQ_LP_READ: begin
                plan  = mk(ST_CMD0, ST_ADDR, ST_CMD1, ST_WAIT, ST_RDATA, ST_END);
                naddr = 3'd5;
            end
            SEQ_STATUS:   plan = mk(ST_CMD0, ST_STAT, ST_END, ST_END, ST_END, ST_END);
            SEQ_SP_READ:  plan = mk(ST_CMD0, ST_ADDR, ST_WAIT, ST_RDATA, ST_END, ST_END);
            default:      known = 1'b0;
        endcase
    end

endmodule

// File: rtl/nfs_bus.sv
module nfs_bus
    import nfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bkind_e     kind,
    input  logic [7:0] byte_in,
    output logic       idle,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    input  logic [7:0] io_in
);

    typedef struct packed {
        ph_e        ph;
        bkind_e     kind;
        logic [7:0] data;
        logic [7:0] rd;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d = bus_q;
        case (bus_q.ph)
            PH_IDLE: begin
                if (start) begin
                    bus_d.ph   = PH_LOW;
                    bus_d.kind = kind;
                    bus_d.data = byte_in;
                end
            end
            PH_LOW: begin
                bus_d.ph = PH_HIGH;
                if (bus_q.kind == BK_RD) begin
                    bus_d.rd = io_in;
                end
            end
            default: bus_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '{ph: PH_IDLE, kind: BK_CMD, data: 8'h00, rd: 8'h00};
        end else begin
            bus_q <= bus_d;
        end
    end

    assign idle    = (bus_q.ph == PH_IDLE);
    assign done    = (bus_q.ph == PH_HIGH);
    assign rd_byte = bus_q.rd;
    assign cle     = (bus_q.ph != PH_IDLE) && (bus_q.kind == BK_CMD);
    assign ale     = (bus_q.ph != PH_IDLE) && (bus_q.kind == BK_ADDR);
    assign we_n    = !((bus_q.ph == PH_LOW) && (bus_q.kind != BK_RD));
    assign re_n    = !((bus_q.ph == PH_LOW) && (bus_q.kind == BK_RD));
    assign io_out  = bus_q.data;
    assign io_oe   = (bus_q.ph != PH_IDLE) && (bus_q.kind != BK_RD);

    // R2
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> we_n);

    // R2
    re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |=> re_n);

    // R2
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |=> (rd_byte == $past(io_in)));

endmodule

// File: rtl/nfs_irq.sv
module nfs_irq #(
    parameter int N_BITS      = 8,
    parameter int CMD_END_BIT = 1,
    parameter int RDY_BIT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_end,
    input  logic              rb_s,
    input  logic              clr,
    input  logic [N_BITS-1:0] mask,
    output logic [N_BITS-1:0] status,
    output logic              irq
);

    typedef struct packed {
        logic [N_BITS-1:0] status;
        logic              rb_prev;
    } irq_t;

    irq_t irq_d, irq_q;
    logic rb_rise;

    assign rb_rise = rb_s && !irq_q.rb_prev;

    always_comb begin
        irq_d         = irq_q;
        irq_d.rb_prev = rb_s;
        if (clr) begin
            irq_d.status = '0;
        end
        if (cmd_end) begin
            irq_d.status[CMD_END_BIT] = 1'b1;
        end
        if (rb_rise) begin
            irq_d.status[RDY_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '{status: '0, rb_prev: 1'b1};
        end else begin
            irq_q <= irq_d;
        end
    end

    assign status = irq_q.status;
    assign irq    = |(irq_q.status & mask);

    // R13
    end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_end |=> status[CMD_END_BIT]);

    // R13
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cmd_end && !rb_rise) |=> (status == '0));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nfs_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int WB_GAP      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic [31:0]      ctrl_word,
    input  logic [31:0]      addr_a_lo,
    input  logic [31:0]      addr_a_hi,
    input  logic [31:0]      addr_b_lo,
    input  logic [31:0]      addr_b_hi,
    input  logic [LEN_W-1:0] data_size,
    output logic             busy,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [7:0]       read_status,
    output logic [7:0]       dev_status,
    input  logic [7:0]       int_mask,
    input  logic             int_clr,
    output logic [7:0]       int_status,
    output logic             irq,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);

    localparam int WB_W  = $clog2(WB_GAP + 1);
    localparam int IDX_W = $clog2(PLAN_LEN);

    // ready line synchroniser
    logic rb_s;
    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic rb_sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rb_sync_q <= 1'b1;
                else        rb_sync_q <= nand_rb;
            end
            assign rb_s = rb_sync_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] rb_sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rb_sync_q <= '1;
                else        rb_sync_q <= {rb_sync_q[SYNC_STAGES-2:0], nand_rb};
            end
            assign rb_s = rb_sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // command decode
    logic        set_sel;
    logic [2:0]  cyc_field;
    logic [63:0] sel_addr;
    logic        dec_known;
    plan_t       dec_plan;
    logic [2:0]  dec_naddr;
    logic        unused_bits;

    assign set_sel     = cmd_word[7];
    assign cyc_field   = set_sel ? ctrl_word[20:18] : ctrl_word[2:0];
    assign sel_addr    = set_sel ? {addr_b_hi, addr_b_lo} : {addr_a_hi, addr_a_lo};
    assign unused_bits = ^{cmd_word[31:24], cmd_word[6], ctrl_word[31:21], ctrl_word[17:3]};

    nfs_decode u_decode (
        .code      (cmd_word[5:0]),
        .cyc_field (cyc_field),
        .known     (dec_known),
        .plan      (dec_plan),
        .naddr     (dec_naddr)
    );

    // byte-transfer engine
    logic       b_start;
    bkind_e     b_kind;
    logic [7:0] b_byte;
    logic       b_idle;
    logic       b_done;
    logic [7:0] b_rd;

    nfs_bus u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (b_start),
        .kind    (b_kind),
        .byte_in (b_byte),
        .idle    (b_idle),
        .done    (b_done),
        .rd_byte (b_rd),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .io_out  (nand_io_out),
        .io_oe   (nand_io_oe),
        .io_in   (nand_io_in)
    );

    // sequencer state
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        plan_t            plan;
        logic [7:0]       c0;
        logic [7:0]       c1;
        logic [63:0]      sh;
        logic [2:0]       acnt;
        logic [LEN_W-1:0] dcnt;
        logic [WB_W-1:0]  wcnt;
        logic [7:0]       rstat;
        logic [7:0]       rdata;
        logic             rdv;
        logic             endp;
    } seq_t;

    seq_t  seq_d, seq_q;
    step_e cur;

    assign cur = step_e'(seq_q.plan[seq_q.idx]);

    always_comb begin
        seq_d      = seq_q;
        seq_d.rdv  = 1'b0;
        seq_d.endp = 1'b0;
        b_start    = 1'b0;
        b_kind     = BK_CMD;
        b_byte     = seq_q.c0;
        wr_ready   = 1'b0;

        if (!seq_q.active) begin
            if (cmd_wr && dec_known) begin
                seq_d.active = 1'b1;
                seq_d.idx    = '0;
                seq_d.plan   = dec_plan;
                seq_d.c0     = cmd_word[15:8];
                seq_d.c1     = cmd_word[23:16];
                seq_d.sh     = sel_addr;
                seq_d.acnt   = dec_naddr;
                seq_d.dcnt   = data_size;
                seq_d.wcnt   = '0;
            end
        end else begin
            case (cur)
                ST_CMD0, ST_CMD1: begin
                    b_kind  = BK_CMD;
                    b_byte  = (cur == ST_CMD0) ? seq_q.c0 : seq_q.c1;
                    b_start = b_idle;
                    if (b_done) seq_d.idx = seq_q.idx + 1'b1;
                end
                ST_ADDR: begin
                    b_kind = BK_ADDR;
                    b_byte = seq_q.sh[7:0];
                    if (seq_q.acnt == 3'd0) begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end else begin
                        b_start = b_idle;
                        if (b_done) begin
                            seq_d.sh   = {8'h00, seq_q.sh[63:8]};
                            seq_d.acnt = seq_q.acnt - 1'b1;
                            if (seq_q.acnt == 3'd1) seq_d.idx = seq_q.idx + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    b_kind = BK_WR;
                    b_byte = wr_data;
                    if (seq_q.dcnt == '0) begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end else begin
                        b_start  = b_idle && wr_valid;
                        wr_ready = b_idle && wr_valid;
                        if (b_done) begin
                            seq_d.dcnt = seq_q.dcnt - 1'b1;
                            if (seq_q.dcnt == LEN_W'(1)) seq_d.idx = seq_q.idx + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    b_kind = BK_RD;
                    if (seq_q.dcnt == '0) begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end else begin
                        b_start = b_idle;
                        if (b_done) begin
                            seq_d.rdata = b_rd;
                            seq_d.rdv   = 1'b1;
                            seq_d.dcnt  = seq_q.dcnt - 1'b1;
                            if (seq_q.dcnt == LEN_W'(1)) seq_d.idx = seq_q.idx + 1'b1;
                        end
                    end
                end
                ST_STAT: begin
                    b_kind  = BK_RD;
                    b_start = b_idle;
                    if (b_done) begin
                        seq_d.rstat = b_rd;
                        seq_d.idx   = seq_q.idx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (seq_q.wcnt != WB_W'(WB_GAP)) begin
                        seq_d.wcnt = seq_q.wcnt + 1'b1;
                    end else if (rb_s) begin
                        seq_d.wcnt = '0;
                        seq_d.idx  = seq_q.idx + 1'b1;
                    end
                end
                default: begin
                    seq_d.active = 1'b0;
                    seq_d.endp   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    nfs_irq #(
        .N_BITS      (8),
        .CMD_END_BIT (1),
        .RDY_BIT     (4)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_end (seq_q.endp),
        .rb_s    (rb_s),
        .clr     (int_clr),
        .mask    (int_mask),
        .status  (int_status),
        .irq     (irq)
    );

    assign busy        = seq_q.active;
    assign rd_data     = seq_q.rdata;
    assign rd_valid    = seq_q.rdv;
    assign read_status = seq_q.rstat;
    assign dev_status  = {8{rb_s}};

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && cmd_wr) |=> ($stable(seq_q.c0) && $stable(seq_q.plan)));

    // R10
    ale_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && nand_ale) |-> (seq_q.active && cur == ST_ADDR));

    // R11
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && cur == ST_WAIT && !rb_s) |=> (nand_we_n && nand_re_n));

    // R5
    wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (wr_valid && !nand_re_n == 1'b0));

endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

    localparam logic [63:0] ADDR_A = 64'h8877665544332211;
    localparam logic [63:0] ADDR_B = 64'hF0E0D0C0B0A09080;

    // vector: {code[5:0], set, cyc[2:0], len[7:0]}
    localparam int NVEC = 11;
    localparam logic [17:0] VEC [NVEC] = '{
        {6'h00, 1'b0, 3'd3, 8'd0},   // R3
        {6'h0E, 1'b0, 3'd3, 8'd0},   // R4 R10
        {6'h0E, 1'b1, 3'd2, 8'd0},   // R4 R10 set 1
        {6'h0C, 1'b0, 3'd4, 8'd3},   // R5
        {6'h0C, 1'b1, 3'd0, 8'd2},   // R5 R10 zero count
        {6'h21, 1'b0, 3'd4, 8'd5},   // R6
        {6'h2A, 1'b1, 3'd2, 8'd4},   // R7
        {6'h24, 1'b0, 3'd3, 8'd0},   // R8
        {6'h32, 1'b0, 3'd3, 8'd4},   // R9
        {6'h32, 1'b1, 3'd5, 8'd0},   // R9 zero length
        {6'h0C, 1'b0, 3'd5, 8'd0}    // R5 zero length
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] ctrl_word = '0;
    logic [15:0] data_size = '0;
    logic        busy, wr_ready, rd_valid, irq;
    logic [7:0]  wr_data, rd_data, read_status, dev_status, int_status;
    logic        wr_valid = 1'b1;
    logic [7:0]  int_mask = '0;
    logic        int_clr = 1'b0;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb = 1'b1;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [9:0] ev_log [1024];
    int ev_n = 0;
    logic [7:0] rd_log [1024];
    int rd_n = 0;
    int ridx = 0, widx = 0, strobe_err = 0;
    bit wr_take = 1'b0, re_prev = 1'b1, we_prev = 1'b1;
    logic [9:0] ex_log [64];
    int ex_n = 0;

    always #2 clk = ~clk;

    assign nand_io_in = 8'hA0 + ridx[7:0];
    assign wr_data    = 8'h50 + widx[7:0];

    nand_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .ctrl_word(ctrl_word), .addr_a_lo(ADDR_A[31:0]), .addr_a_hi(ADDR_A[63:32]),
        .addr_b_lo(ADDR_B[31:0]), .addr_b_hi(ADDR_B[63:32]), .data_size(data_size),
        .busy(busy), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .read_status(read_status),
        .dev_status(dev_status), .int_mask(int_mask), .int_clr(int_clr),
        .int_status(int_status), .irq(irq), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    // pin monitor: kinds 0=command 1=address 2=write 3=read
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) begin
                ev_log[ev_n] = {nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2), nand_io_out};
                ev_n++;
            end
            if (!nand_re_n) begin
                ev_log[ev_n] = {2'd3, nand_io_in};
                ev_n++;
            end
            // R2 strobe shape
            if (nand_cle && nand_ale) strobe_err++;
            if (!nand_we_n && !we_prev) strobe_err++;
            if (!nand_re_n && !re_prev) strobe_err++;
            if (!nand_re_n && nand_io_oe) strobe_err++;
            if (!nand_we_n && !nand_cle && !nand_ale && !nand_io_oe) strobe_err++;
            if (rd_valid) begin
                rd_log[rd_n] = rd_data;
                rd_n++;
            end
            if (wr_take) widx++;
            wr_take = wr_ready;
            if (!re_prev && nand_re_n) ridx++;
            re_prev = nand_re_n;
            we_prev = nand_we_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] b);
        ex_log[ex_n] = {k, b};
        ex_n++;
    endtask

    task automatic push_addr(input logic [63:0] a, input int n);
        for (int i = 0; i < n; i++) push(2'd1, a[i*8 +: 8]);
    endtask

    task automatic issue(input logic [5:0] code, input bit set, input logic [2:0] cyc3,
                         input logic [7:0] len, input logic [7:0] c0, input logic [7:0] c1);
        logic [2:0] other;
        other = (cyc3 == 3'd6) ? 3'd2 : 3'd6;
        @(negedge clk);
        cmd_word  = {8'hC5, c1, c0, set, 1'b1, code};
        ctrl_word = set ? {11'b0, cyc3, 15'b0, other} : {11'b0, other, 15'b0, cyc3};
        data_size = {8'h00, len};
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        int_clr = 1'b1;
        @(negedge clk);
        int_clr = 1'b0;
    endtask

    task automatic cmp_events(input int base, input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < ex_n; i++)
            if (bad < 0 && ev_log[base + i] !== ex_log[i]) bad = i;
        chk(ev_n - base == ex_n, req, "transfer count", 64'(ev_n - base), 64'(ex_n));
        if (bad >= 0)
            chk(1'b0, req, "transfer order", {54'b0, ev_log[base + bad]}, {54'b0, ex_log[bad]});
        else
            chk(1'b1, req, "transfer order", 0, 0);
    endtask

    initial begin
        // R14 reset state
        repeat (3) @(negedge clk);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R14", "strobes",
            {60'b0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 64'hC);
        chk(!busy && int_status == 8'h00 && !irq, "R14", "busy/int",
            {55'b0, busy, int_status}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dev_status == 8'hFF, "R11", "dev_status ready", 64'(dev_status), 64'hFF);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [5:0] code;
            bit set;
            logic [2:0] cyc3;
            logic [7:0] len, c0, c1;
            logic [63:0] a;
            int na, eb, rb0, wb0, rdb, nrd;
            string req;
            {code, set, cyc3, len} = VEC[v];
            c0 = 8'h10 + 8'(v);
            c1 = 8'h30 + 8'(v);
            a  = set ? ADDR_B : ADDR_A;
            na = (code == 6'h21) ? 1 : (code == 6'h2A) ? 5 : int'(cyc3);
            eb = ev_n; rb0 = ridx; wb0 = widx; rdb = rd_n; nrd = 0;
            ex_n = 0;
            push(2'd0, c0);
            case (code)
                6'h00: req = "R3";
                6'h0E: begin req = "R4"; push_addr(a, na); push(2'd0, c1); end
                6'h0C: begin
                    req = "R5"; push_addr(a, na);
                    for (int k = 0; k < int'(len); k++) push(2'd2, 8'h50 + 8'(wb0 + k));
                    push(2'd0, c1);
                end
                6'h21: begin req = "R6"; push_addr(a, na); nrd = int'(len); end
                6'h2A: begin req = "R7"; push_addr(a, na); push(2'd0, c1); nrd = int'(len); end
                6'h24: begin req = "R8"; push(2'd3, 8'hA0 + 8'(rb0)); end
                default: begin req = "R9"; push_addr(a, na); nrd = int'(len); end
            endcase
            for (int k = 0; k < nrd; k++) push(2'd3, 8'hA0 + 8'(rb0 + k));
            if (v == 2 || v == 4) req = {req, " R10"};
            issue(code, set, cyc3, len, c0, c1);
            chk(busy, "R12", "busy after write", {63'b0, busy}, 1);
            wait_idle();
            cmp_events(eb, req);
            chk(rd_n - rdb == nrd, req, "rd_valid count", 64'(rd_n - rdb), 64'(nrd));
            for (int k = 0; k < nrd && k < rd_n - rdb; k++)
                chk(rd_log[rdb + k] == 8'hA0 + 8'(rb0 + k), req, "rd_data",
                    64'(rd_log[rdb + k]), 64'(8'hA0 + 8'(rb0 + k)));
            if (code == 6'h24)
                chk(read_status == 8'hA0 + 8'(rb0), "R8", "read_status",
                    64'(read_status), 64'(8'hA0 + 8'(rb0)));
            chk(int_status == 8'h02, "R13", "command end bit", 64'(int_status), 64'h02);
            pulse_clr();
        end

        // R1 command-byte fields and R12 command write while busy
        begin
            int eb;
            eb = ev_n; ex_n = 0;
            push(2'd0, 8'h77); push_addr(ADDR_A, 3); push(2'd0, 8'h78);
            issue(6'h0E, 1'b0, 3'd3, 8'd0, 8'h77, 8'h78);
            @(negedge clk);
            cmd_word = {8'h00, 8'h00, 8'hEE, 8'h00};
            cmd_wr = 1'b1;
            @(negedge clk);
            cmd_wr = 1'b0;
            wait_idle();
            cmp_events(eb, "R12 R1");
            chk(!busy, "R12", "idle after one sequence", {63'b0, busy}, 0);
            pulse_clr();
        end

        // R12 undefined code ignored
        begin
            int eb;
            bit seen;
            eb = ev_n; seen = 1'b0;
            issue(6'h15, 1'b0, 3'd3, 8'd2, 8'h99, 8'h9A);
            for (int i = 0; i < 12; i++) begin
                if (busy) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R12", "undefined code busy", {63'b0, seen}, 0);
            chk(ev_n == eb, "R12", "undefined code strobes", 64'(ev_n - eb), 0);
            chk(int_status == 8'h00, "R12", "undefined code int", 64'(int_status), 0);
        end

        // R11 ready wait holds the data phase
        begin
            int eb;
            eb = ev_n;
            nand_rb = 1'b0;
            repeat (4) @(negedge clk);
            chk(dev_status == 8'h00, "R11", "dev_status busy", 64'(dev_status), 0);
            issue(6'h2A, 1'b0, 3'd1, 8'd2, 8'h00, 8'h30);
            repeat (60) @(negedge clk);
            chk(busy, "R11", "busy during hold", {63'b0, busy}, 1);
            chk(ev_n - eb == 7, "R11", "no reads before ready", 64'(ev_n - eb), 7);
            nand_rb = 1'b1;
            wait_idle();
            chk(ev_n - eb == 9 && ev_log[eb + 7][9:8] == 2'd3, "R11", "reads after ready",
                64'(ev_n - eb), 9);
            chk(dev_status == 8'hFF, "R11", "dev_status ready again", 64'(dev_status), 64'hFF);
            chk(int_status == 8'h12, "R13", "ready and end bits", 64'(int_status), 64'h12);
        end

        // R13 mask and clear
        @(negedge clk); int_mask = 8'h00;
        @(negedge clk);
        chk(!irq, "R13", "irq masked off", {63'b0, irq}, 0);
        int_mask = 8'h10;
        @(negedge clk);
        chk(irq, "R13", "irq on ready bit", {63'b0, irq}, 1);
        int_mask = 8'h01;
        @(negedge clk);
        chk(!irq, "R13", "irq unrelated mask", {63'b0, irq}, 0);
        int_mask = 8'hFF;
        pulse_clr();
        @(negedge clk);
        chk(int_status == 8'h00 && !irq, "R13", "cleared", {55'b0, irq, int_status}, 0);

        chk(strobe_err == 0, "R2", "strobe shape errors", 64'(strobe_err), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule